// File: doc/BRIEF.md
# Phase-Loop Lock Monitor with Asymmetric Hysteresis

This block watches the two correction pulses (pump-up and pump-down) that a phase-frequency detector produces. It keeps a single lock flag. It runs on the crystal clock, so the width of each correction pulse is measured directly in crystal cycles. A one-cycle strobe marks the boundary between reference periods. The detector is normally aligned with the reference edge, so a locked loop only produces pulses narrower than one crystal period.

The flag reacts unevenly to good and bad periods. One pulse wider than the threshold clears the flag at once, in the middle of the period and without waiting for the next strobe. Setting the flag again takes a long run of clean periods: it sets only at the strobe that closes the eighth clean period in a row. A period counts as clean when no pulse in it exceeded the threshold, and a period with no pulse at all is clean. A new rise on either pulse line starts its width measurement from one again, even when the other line was high just before. The result is that a loop that has just settled has to stay quiet for a while before software trusts it.

All pins are plain control and status signals. Nothing flows as a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `locked` is 0.
- R2: A pulse on `pump_up`, `pump_dn`, or both at once, that lasts at most THRESH_CYC (default 1) crystal cycles never clears `locked`.
- R3: When `pump_up` stays high for THRESH_CYC+1 cycles with no new rise in between, `locked` is 0 from the clock edge that ends the last of those cycles.
- R4: A `pump_dn` pulse longer than THRESH_CYC cycles clears `locked` in the same way as R3.
- R5: A rise on either line restarts the width measurement. One line falling in the same cycle as the other rises therefore gives two narrow pulses, not one wide pulse.
- R6: `locked` goes to 1 on the clock edge of the `ref_tick` cycle that closes the RUN_LEN-th (default 8) consecutive clean period. It is never set at any other time.
- R7: A wide pulse resets the clean-period run to zero. After the wide pulse, RUN_LEN further clean periods are needed before `locked` sets.
- R8: A wide pulse that is detected in the `ref_tick` cycle itself counts against the period that this tick closes.
- R9: Once `locked` is 1, it stays 1 through any number of clean periods, including periods with no pulse at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock. Pulse width is measured in its cycles |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ref_tick | input | 1 | One-cycle strobe that closes each reference period |
| pump_up | input | 1 | Pump-up correction pulse from the phase detector |
| pump_dn | input | 1 | Pump-down correction pulse from the phase detector |
| locked | output | 1 | Lock flag |

## Verification
Every result of this block is due on the first clock edge after the cycle that causes it. A drop is due at the edge that ends the wide pulse's (THRESH_CYC+1)-th cycle. A set is due at the edge of the closing `ref_tick` cycle. The driver applies one cycle of stimulus at the falling edge. It pushes the value of `locked` that is expected after the next rising edge, worked out from the requirements. The monitor pops that value and compares it 1 ns after that rising edge, so exactly one prediction is checked against each cycle.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

  // Verdict on a closing reference period, as seen by the run counter.
  typedef enum logic [1:0] {
    PER_NONE  = 2'd0,  // no strobe this cycle
    PER_CLEAN = 2'd1,  // strobe, and the period had no wide pulse
    PER_DIRTY = 2'd2   // strobe, and the period had a wide pulse
  } period_verdict_e;

  // Number of bits needed to hold the value n.
  function automatic int bits_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lockmon_pulse_meter.sv
module lockmon_pulse_meter
  import lockmon_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int THRESH_CYC = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pulse_i,
  output logic           wide_o
);

  localparam int SAT = THRESH_CYC + 1;
  localparam int CW  = bits_for(SAT);

  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] rise;
  logic [CW-1:0]  width_q, width_nxt;
  logic           any_high;

  // One edge detector per correction line.
  for (genvar c = 0; c < NCH; c++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[c] <= 1'b0;
      else        prev_q[c] <= pulse_i[c];
    end
    assign rise[c] = pulse_i[c] & ~prev_q[c];
  end

  assign any_high = |pulse_i;

  // Saturating width counter, restarting on any new rise.
  always_comb begin
    if (!any_high)               width_nxt = '0;
    else if (|rise)              width_nxt = CW'(1);
    else if (width_q == CW'(SAT)) width_nxt = width_q;
    else                         width_nxt = width_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) width_q <= '0;
    else        width_q <= width_nxt;
  end

  assign wide_o = any_high && (width_nxt > CW'(THRESH_CYC));

endmodule

// File: rtl/lockmon_period_judge.sv
module lockmon_period_judge
  import lockmon_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            wide_i,
  output period_verdict_e verdict_o
);

  logic seen_q;

  // Remembers a wide pulse until the strobe closes the period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= 1'b0;
    else if (tick_i) seen_q <= 1'b0;
    else if (wide_i) seen_q <= 1'b1;
  end

  always_comb begin
    if (!tick_i)               verdict_o = PER_NONE;
    else if (seen_q || wide_i) verdict_o = PER_DIRTY;
    else                       verdict_o = PER_CLEAN;
  end

endmodule

// File: rtl/lockmon_run_counter.sv
module lockmon_run_counter
  import lockmon_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_i,
  input  period_verdict_e verdict_i,
  output logic            reached_o
);

  localparam int RW = bits_for(RUN_LEN);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (wide_i || verdict_i == PER_DIRTY) begin
      run_q <= '0;
    end else if (verdict_i == PER_CLEAN && run_q != RW'(RUN_LEN)) begin
      run_q <= run_q + RW'(1);
    end
  end

  assign reached_o = (verdict_i == PER_CLEAN) && (run_q >= RW'(RUN_LEN - 1));

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import lockmon_pkg::*;
#(
  parameter int THRESH_CYC = 1,
  parameter int RUN_LEN    = 8
) (
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic pump_up,
  input  logic pump_dn,
  output logic locked
);

  logic            wide;
  logic            reached;
  period_verdict_e verdict;
  logic            lock_q;

  lockmon_pulse_meter #(.NCH(2), .THRESH_CYC(THRESH_CYC)) u_meter (
    .clk     (clk_xtal),
    .rst_n   (rst_n),
    .pulse_i ({pump_dn, pump_up}),
    .wide_o  (wide)
  );

  lockmon_period_judge u_judge (
    .clk       (clk_xtal),
    .rst_n     (rst_n),
    .tick_i    (ref_tick),
    .wide_i    (wide),
    .verdict_o (verdict)
  );

  lockmon_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk_xtal),
    .rst_n     (rst_n),
    .wide_i    (wide),
    .verdict_i (verdict),
    .reached_o (reached)
  );

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (wide)    lock_q <= 1'b0;
    else if (reached) lock_q <= 1'b1;
  end

  assign locked = lock_q;

endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk (
  input logic clk_xtal,
  input logic rst_n,
  input logic ref_tick,
  input logic pump_up,
  input logic pump_dn,
  input logic locked
);

  // R1: flag held low during reset
  always @(negedge clk_xtal) begin
    if (!rst_n) begin
      p_reset_low_r1: assert (!locked);
    end
  end

  // R3: up high two cycles running, no fresh dn rise, clears the flag
  p_up_wide_drop_r3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    ($past(rst_n) && pump_up && $past(pump_up) && !(pump_dn && !$past(pump_dn)))
    |=> !locked);

  // R4: same for the down line
  p_dn_wide_drop_r4: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    ($past(rst_n) && pump_dn && $past(pump_dn) && !(pump_up && !$past(pump_up)))
    |=> !locked);

  // R6: the flag only rises at a period strobe
  p_set_on_tick_r6: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_tick));

  // R2: the flag only falls after a correction pulse
  p_drop_needs_pulse_r2: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $fell(locked) |-> $past(pump_up || pump_dn));

  // R9: with no pulse the flag holds
  p_hold_quiet_r9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (locked && !pump_up && !pump_dn) |=> locked);

endmodule

bind pll_lock_monitor pll_lock_monitor_chk u_chk (
  .clk_xtal (clk_xtal),
  .rst_n    (rst_n),
  .ref_tick (ref_tick),
  .pump_up  (pump_up),
  .pump_dn  (pump_dn),
  .locked   (locked)
);

// File: tb/tb_pll_lock_monitor.sv
module tb_pll_lock_monitor;

  localparam int TH  = 1;
  localparam int RUN = 8;
  localparam int PER = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, pump_up = 1'b0, pump_dn = 1'b0;
  logic locked;

  always #2.5 clk = ~clk;

  pll_lock_monitor #(.THRESH_CYC(TH), .RUN_LEN(RUN)) dut (
    .clk_xtal (clk), .rst_n (rst_n), .ref_tick (ref_tick),
    .pump_up (pump_up), .pump_dn (pump_dn), .locked (locked)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;

  // Requirement-level model state.
  logic m_upq = 0, m_dnq = 0, m_seen = 0, m_lock = 0;
  int   m_w = 0, m_run = 0;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: locked=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle; push the flag value due after the next rising edge.
  task automatic step(input logic up, input logic dn, input logic tk, input string tag);
    logic rise, p, wide;
    item_t it;
    @(negedge clk);
    pump_up = up; pump_dn = dn; ref_tick = tk;
    rise = (up && !m_upq) || (dn && !m_dnq);
    p    = up || dn;
    if (!p)        m_w = 0;
    else if (rise) m_w = 1;
    else if (m_w < TH + 1) m_w = m_w + 1;
    wide = p && (m_w > TH);
    if (wide) begin
      m_lock = 0; m_run = 0;
    end else if (tk) begin
      if (m_seen) m_run = 0;
      else begin
        if (m_run < RUN) m_run = m_run + 1;
        if (m_run >= RUN) m_lock = 1;
      end
    end
    m_seen = tk ? 1'b0 : (m_seen || wide);
    m_upq = up; m_dnq = dn;
    it.exp = m_lock; it.tag = tag;
    q.push_back(it);
  endtask

  // Kinds of pulse placed in a period.
  typedef enum int { K_NONE, K_UP1, K_DN1, K_BOTH1, K_UP2, K_DN3, K_UPDN, K_TICKWIDE } kind_e;

  task automatic period(input kind_e k, input string tag);
    for (int c = 0; c < PER; c++) begin
      logic up, dn, tk;
      up = 0; dn = 0; tk = (c == PER - 1);
      case (k)
        K_UP1:     up = (c == 3);
        K_DN1:     dn = (c == 3);
        K_BOTH1:   begin up = (c == 3); dn = (c == 3); end
        K_UP2:     up = (c == 3 || c == 4);
        K_DN3:     dn = (c >= 5 && c <= 7);
        K_UPDN:    begin up = (c == 3); dn = (c == 4); end
        K_TICKWIDE: up = (c >= PER - 2);
        default: ;
      endcase
      step(up, dn, tk, tag);
    end
  endtask

  // Monitor: compare 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(locked, it.exp, it.tag);
      end
    end
  end

  initial begin
    #20000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(locked, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(locked, 1'b0, "R1 after release");

    // R6/R2: eight clean periods of narrow pulses set the flag.
    for (int i = 0; i < RUN; i++) period(i % 2 ? K_DN1 : K_UP1, "R6 acquire");
    // R9: quiet and narrow periods keep it.
    for (int i = 0; i < 3; i++) period(K_NONE, "R9 quiet hold");
    period(K_BOTH1, "R2 both narrow");
    // R3: wide up pulse drops it.
    period(K_UP2, "R3 wide up");
    // R7/R4: partial run, wide down pulse, full run again.
    for (int i = 0; i < 5; i++) period(K_UP1, "R7 partial run");
    period(K_DN3, "R4 wide down");
    for (int i = 0; i < RUN; i++) period(K_NONE, "R7 rerun");
    // R5: back-to-back up then down keeps the flag.
    for (int i = 0; i < 3; i++) period(K_UPDN, "R5 restart");
    // R8: wide pulse in the strobe cycle spoils that period.
    period(K_TICKWIDE, "R8 wide at tick");
    for (int i = 0; i < RUN - 1; i++) period(K_UP1, "R8 seven clean");
    period(K_UP1, "R6 eighth clean");
    period(K_NONE, "R9 final hold");

    @(posedge clk); #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule